// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 64-bit integer register datapath and a 64-bit, byte-addressed data memory port. On a load it takes the raw eight-byte memory word, picks out the one, two, four or eight bytes named by the effective address and the access size, and returns them right-justified in a 64-bit result. Narrow results are zero-filled or sign-filled according to a per-access signed flag. On a store it repeats the narrow register value across every byte lane of the write word and raises a byte-enable bit only on the lanes the access covers.

A run-time endianness input selects how byte offsets within the eight-byte word map onto lanes. Little-endian places offset k on lane k, with the lowest-addressed byte least significant. Big-endian places offset k on lane 7-k, with the lowest-addressed byte most significant. An access whose address is not a multiple of its size raises a fault. A faulting access writes no lanes and returns zero load data. The logic is combinational by default. Setting a parameter adds one output register stage with an asynchronous active-low reset.

Top module: `mem_lane_align`

## Requirements
- R1: `alignFault` is 1 exactly when `accAddr[2:0]` is not a multiple of the access size. Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes.
- R2: In little-endian mode (`bigEnd`=0), the byte at offset k is taken from lane k (bits 8k+7..8k) of `memRdData`. The lowest-addressed byte becomes the least significant byte of the result.
- R3: In big-endian mode (`bigEnd`=1), the byte at offset k is taken from lane 7-k. The lowest-addressed byte becomes the most significant byte of the result.
- R4: For 1-, 2- and 4-byte loads, the bits above the loaded value are copies of its top bit when `accSigned`=1, and are zero when `accSigned`=0.
- R5: An aligned 8-byte load returns `memRdData` unchanged in both modes, whatever the value of `accSigned`.
- R6: A faulting access drives `loadData` to zero and `byteEn` to zero.
- R7: `memWrData` lane k carries byte (k mod n) of `storeData`, where n is the access size in bytes. This holds in both modes and needs no byte swap.
- R8: On an aligned store (`isStore`=1), `byteEn` bit k is 1 exactly when lane k holds an addressed byte. In little-endian mode these are lanes o..o+n-1, where o = `accAddr[2:0]`; big-endian mode uses the mirror of that mask. `byteEn` is zero on loads.
- R9: Address bits above bit 2 have no effect on any output.
- R10: With `OUT_REG`=1, every output appears one clock after its inputs and is zero while `rstN` is low. With `OUT_REG`=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Asynchronous active-low reset |
| isStore | input | 1 | 1 for a store, 0 for a load |
| accAddr | input | ADDR_W | Effective byte address |
| accSize | input | 2 | Access size code (0=1B, 1=2B, 2=4B, 3=8B) |
| accSigned | input | 1 | Sign-extend narrow loads when 1 |
| bigEnd | input | 1 | Big-endian lane order when 1 |
| memRdData | input | 64 | Word read from memory |
| storeData | input | 64 | Register value to store |
| loadData | output | 64 | Aligned, extended load result |
| memWrData | output | 64 | Lane-replicated store word |
| byteEn | output | 8 | Per-lane write enables |
| alignFault | output | 1 | Misaligned access |

## Verification
The hardest case to reach is a narrow signed load in big-endian mode at a nonzero offset whose top loaded bit is set. Here lane selection, the significance order and sign fill must all agree at once, and the result differs from the little-endian result only in bits that random data often leaves equal. The stimulus fixes a memory word whose lanes are all distinct and have their top bits set, then runs directed big-endian half-word and word loads at every aligned offset. A long random phase then mixes misaligned addresses with random upper address bits.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;
  localparam int OFFS_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              fault;
    logic              signExt;
    accSize_e          size;
    logic [OFFS_W-1:0] lowLane;
    logic [LANES-1:0]  laneMask;
  } laneStrobe_t;
endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFFS_W-1:0] addrLow,
  input  accSize_e          size,
  input  logic              accSigned,
  input  logic              bigEnd,
  input  logic              isStore,
  output laneStrobe_t       strobe
);
  logic [OFFS_W:0]    nBytes;
  logic [OFFS_W:0]    endLane;
  logic [OFFS_W:0]    beLow;
  logic [LANES-1:0]   leMask;
  logic [LANES-1:0]   beMask;
  logic               misaligned;

  assign nBytes     = {{OFFS_W{1'b0}}, 1'b1} << size;
  assign endLane    = {1'b0, addrLow} + nBytes;
  assign misaligned = |(addrLow & (nBytes[OFFS_W-1:0] - 1'b1));
  // big-endian: lowest-significance byte sits at the lowest covered lane
  assign beLow      = (OFFS_W+1)'(LANES) - {1'b0, addrLow} - nBytes;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [OFFS_W:0] LaneIdx = (OFFS_W+1)'(k);
    assign leMask[k] = (LaneIdx >= {1'b0, addrLow}) && (LaneIdx < endLane);
    assign beMask[k] = leMask[LANES-1-k];
  end

  always_comb begin
    strobe.fault    = misaligned;
    strobe.signExt  = accSigned;
    strobe.size     = size;
    strobe.lowLane  = bigEnd ? beLow[OFFS_W-1:0] : addrLow;
    strobe.laneMask = (misaligned || !isStore) ? '0 : (bigEnd ? beMask : leMask);
  end

  // R8: an aligned store enables exactly as many lanes as the size has bytes
  a_r8_mask_popcount: assert property (@(posedge clk) disable iff (!rstN)
    (isStore && !strobe.fault) |-> ($countones(strobe.laneMask) == int'(nBytes)));
  // R3: big-endian covered lanes end at the mirrored offset
  a_r3_be_top_lane: assert property (@(posedge clk) disable iff (!rstN)
    (bigEnd && !strobe.fault) |-> (int'(strobe.lowLane) + int'(nBytes) == LANES - int'(addrLow)));
endmodule

// File: rtl/lane_dp.sv
module lane_dp
  import lane_pkg::*;
(
  input  laneStrobe_t       strobe,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [DATA_W-1:0] storeData,
  output logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] wrData
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] extVal;

  assign shifted = memRdData >> {strobe.lowLane, 3'b000};

  always_comb begin
    unique case (strobe.size)
      SZ_BYTE:  extVal = {{(DATA_W-8){strobe.signExt & shifted[7]}},   shifted[7:0]};
      SZ_HALF:  extVal = {{(DATA_W-16){strobe.signExt & shifted[15]}}, shifted[15:0]};
      SZ_WORD:  extVal = {{(DATA_W-32){strobe.signExt & shifted[31]}}, shifted[31:0]};
      default:  extVal = shifted;
    endcase
  end

  assign loadData = strobe.fault ? '0 : extVal;

  // store lane replication: lane k takes byte (k mod size)
  for (genvar k = 0; k < LANES; k++) begin : g_wr
    logic [7:0] laneByte;
    always_comb begin
      unique case (strobe.size)
        SZ_BYTE: laneByte = storeData[7:0];
        SZ_HALF: laneByte = storeData[8*(k%2) +: 8];
        SZ_WORD: laneByte = storeData[8*(k%4) +: 8];
        default: laneByte = storeData[8*k +: 8];
      endcase
    end
    assign wrData[8*k +: 8] = laneByte;
  end
endmodule

// File: rtl/mem_lane_align.sv
module mem_lane_align
  import lane_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isStore,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic              accSigned,
  input  logic              bigEnd,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [DATA_W-1:0] storeData,
  output logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] memWrData,
  output logic [LANES-1:0]  byteEn,
  output logic              alignFault
);
  laneStrobe_t       strobe;
  logic [DATA_W-1:0] loadComb;
  logic [DATA_W-1:0] wrComb;
  logic              unusedAddrHi;

  assign unusedAddrHi = ^accAddr[ADDR_W-1:OFFS_W];

  lane_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrLow  (accAddr[OFFS_W-1:0]),
    .size     (accSize_e'(accSize)),
    .accSigned(accSigned),
    .bigEnd   (bigEnd),
    .isStore  (isStore),
    .strobe   (strobe)
  );

  lane_dp u_dp (
    .strobe   (strobe),
    .memRdData(memRdData),
    .storeData(storeData),
    .loadData (loadComb),
    .wrData   (wrComb)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loadData   <= '0;
        memWrData  <= '0;
        byteEn     <= '0;
        alignFault <= 1'b0;
      end else begin
        loadData   <= loadComb;
        memWrData  <= wrComb;
        byteEn     <= strobe.laneMask;
        alignFault <= strobe.fault;
      end
    end
    // R10: registered outputs trail the combinational result by one clock
    a_r10_fault_latency: assert property (@(posedge clk) disable iff (!rstN)
      strobe.fault |=> alignFault);
    a_r10_load_latency: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.fault |=> (loadData == $past(loadComb)));
  end else begin : g_comb
    assign loadData   = loadComb;
    assign memWrData  = wrComb;
    assign byteEn     = strobe.laneMask;
    assign alignFault = strobe.fault;
    // R10: combinational variant answers in the same cycle
    a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rstN)
      strobe.fault |-> (alignFault && loadData == '0));
  end

  // R6: a fault never returns load data
  a_r6_fault_zero_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fault |-> (loadComb == '0));
  // R5: aligned double word passes through untouched
  a_r5_dword_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'd3 && !strobe.fault) |-> (loadComb == memRdData));
  // R4: signed byte loads fill upper bits with the value's top bit
  a_r4_byte_sign_fill: assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'd0 && accSigned && !strobe.fault) |->
      (loadComb[DATA_W-1:8] == {(DATA_W-8){loadComb[7]}}));
  a_r4_byte_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'd0 && !accSigned) |-> (loadComb[DATA_W-1:8] == '0));
endmodule

// File: tb/mem_lane_align_bench.sv
module mem_lane_align_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        isStore = 1'b0;
  logic [63:0] accAddr = '0;
  logic [1:0]  accSize = '0;
  logic        accSigned = 1'b0;
  logic        bigEnd = 1'b0;
  logic [63:0] memRdData = '0;
  logic [63:0] storeData = '0;
  logic [63:0] loadData, memWrData;
  logic [7:0]  byteEn;
  logic        alignFault;

  int checks = 0;
  int fails  = 0;

  logic [63:0] pendLd, pendWr;
  logic [7:0]  pendEn;
  logic        pendFlt;
  string       pendTag;
  bit          pendValid = 1'b0;

  always #4 clk = ~clk;

  mem_lane_align #(.ADDR_W(64), .OUT_REG(1'b1)) u_mem_lane_align (
    .clk(clk), .rstN(rstN), .isStore(isStore), .accAddr(accAddr),
    .accSize(accSize), .accSigned(accSigned), .bigEnd(bigEnd),
    .memRdData(memRdData), .storeData(storeData), .loadData(loadData),
    .memWrData(memWrData), .byteEn(byteEn), .alignFault(alignFault)
  );

  function automatic void refModel(input logic st, input logic [63:0] addr,
      input logic [1:0] sz, input logic sgn, input logic be,
      input logic [63:0] rd, input logic [63:0] sd,
      output logic [63:0] ld, output logic [63:0] wr,
      output logic [7:0] en, output logic flt);
    int n = 1 << sz;
    int o = int'(addr[2:0]);
    int lane, sig;
    logic [63:0] v = '0;
    logic [7:0] m = '0;
    flt = (o % n) != 0;
    if (!flt) begin
      for (int i = 0; i < n; i++) begin
        lane = be ? 7 - (o + i) : o + i;
        sig  = be ? n - 1 - i : i;
        v[8*sig +: 8] = rd[8*lane +: 8];
        m[lane] = 1'b1;
      end
      if (n < 8 && sgn && v[8*n-1])
        for (int b = 8*n; b < 64; b++) v[b] = 1'b1;
    end
    ld = flt ? 64'd0 : v;
    en = (flt || !st) ? 8'd0 : m;
    for (int k = 0; k < 8; k++) wr[8*k +: 8] = sd[8*(k % n) +: 8];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic comparePending();
    if (pendValid) begin
      chk(pendTag, "loadData", loadData, pendLd);
      chk("R7", "memWrData", memWrData, pendWr);
      chk("R8", "byteEn", {56'd0, byteEn}, {56'd0, pendEn});
      chk("R1", "alignFault", {63'd0, alignFault}, {63'd0, pendFlt});
    end
  endtask

  // drive at negedge; the registered result is checked one negedge later
  task automatic step(input string tag, input logic st, input logic [63:0] addr,
                      input logic [1:0] sz, input logic sgn, input logic be,
                      input logic [63:0] rd, input logic [63:0] sd);
    @(negedge clk);
    comparePending();
    isStore = st; accAddr = addr; accSize = sz; accSigned = sgn;
    bigEnd = be; memRdData = rd; storeData = sd;
    refModel(st, addr, sz, sgn, be, rd, sd, pendLd, pendWr, pendEn, pendFlt);
    if (tag != "") pendTag = tag;
    else if (pendFlt) pendTag = "R6";
    else if (sz == 2'd3) pendTag = "R5";
    else pendTag = be ? "R3" : "R2";
    pendValid = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] mw = 64'hF8E7_D6C5_B4A3_9281;
    // R10: outputs held at zero in reset even with live inputs
    isStore = 1'b1; accSize = 2'd3; memRdData = mw; storeData = mw;
    repeat (3) @(negedge clk);
    chk("R10", "loadData in reset", loadData, 64'd0);
    chk("R10", "memWrData in reset", memWrData, 64'd0);
    chk("R10", "byteEn in reset", {56'd0, byteEn}, 64'd0);
    rstN = 1'b1;

    // R2: little-endian byte and half
    step("R2", 0, 64'h10, 2'd0, 0, 0, mw, 0);
    step("R2", 0, 64'h16, 2'd1, 0, 0, mw, 0);
    // R4: signed and unsigned fills
    step("R4", 0, 64'h07, 2'd0, 1, 0, mw, 0);
    step("R4", 0, 64'h04, 2'd2, 1, 0, mw, 0);
    step("R4", 0, 64'h04, 2'd2, 0, 0, mw, 0);
    // R3: big-endian loads at every aligned offset, signed
    for (int o = 0; o < 8; o += 2) step("R3", 0, 64'(o), 2'd1, 1, 1, mw, 0);
    for (int o = 0; o < 8; o += 4) step("R3", 0, 64'(o), 2'd2, 1, 1, mw, 0);
    step("R3", 0, 64'h00, 2'd0, 0, 1, mw, 0);
    // R5: double word both modes
    step("R5", 0, 64'h08, 2'd3, 1, 1, mw, 0);
    step("R5", 0, 64'h08, 2'd3, 1, 0, mw, 0);
    // R6/R1: misaligned load and store
    step("R6", 0, 64'h01, 2'd1, 1, 0, mw, 0);
    step("R6", 1, 64'h06, 2'd2, 0, 1, mw, 64'h1122_3344_5566_7788);
    step("R6", 1, 64'h04, 2'd3, 0, 0, mw, 64'h1);
    // R7/R8: stores in both modes
    step("R2", 1, 64'h01, 2'd0, 0, 1, mw, 64'hAB);
    step("R2", 1, 64'h06, 2'd1, 0, 0, mw, 64'hCDEF);
    step("R2", 1, 64'h04, 2'd2, 0, 1, mw, 64'h0123_4567);
    // R9: upper address bits ignored
    step("R9", 0, 64'hFFFF_0000_1234_5673, 2'd0, 1, 1, mw, 0);
    step("R9", 1, 64'h8000_0000_0000_0002, 2'd1, 1, 0, mw, 64'h5A5A);

    for (int i = 0; i < 4000; i++) begin
      step("", 1'($urandom), {$urandom, $urandom}, 2'($urandom), 1'($urandom),
           1'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    end
    @(negedge clk);
    comparePending();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule